// File: doc/BRIEF.md
# Sensor burst bridge

The bridge sits between a host SPI port and an array of SPI sensors. The host opens a frame with a four-byte header naming a first sensor slot, a byte count per sensor, a number of sensors and one register address. The bridge then becomes bus master on the sensor side. It selects each sensor in the span in turn, sends it the register byte and reads back the requested bytes. All of the results return to the host as one unbroken stream in slot order.

Slots that hold no sensor, and slots past the end of the array, produce 0xFF bytes, so the stream length is always fixed by the header. A first-slot byte whose top bit is clear addresses a small internal byte register file instead of the sensors.

Both ports are sampled in the block clock. The host clock must run several times slower than the block clock. The host must also leave a lead time after the header, long enough for the first sensor byte to arrive. The sensor clock runs at half the block clock and stalls between bytes whenever the internal byte queue is full.

Top module: `sensor_burst_bridge`

## Requirements
- R1: The host header is four bytes sent MSB first, in this order: first slot byte, bytes per sensor, sensor count, register byte. Data bytes follow the header directly, with no filler.
- R2: Only the low 6 bits of the bytes-per-sensor and sensor-count bytes are used; their top two bits have no effect on the stream.
- R3: A first slot byte of 0x80+n starts at slot n, and slot n is selected by driving bit n of `sen_cs_n` low.
- R4: Each selected sensor first receives the header's register byte, MSB first on `sen_mosi`, in SPI mode 0. It then gets the requested number of data bytes read from `sen_miso`.
- R5: A slot whose `sen_present` bit is 0 is never selected. It contributes bytes-per-sensor bytes of 0xFF, so the stream is always count × size bytes long.
- R6: Slots at index NSLOT or above are never selected and return 0xFF for their share of the stream.
- R7: The stream carries each slot's bytes in ascending slot order, and is correct while the sensor clock has to stall because the queue is full.
- R8: After the host clocks the last data bit, `host_miso_oe` drops while `host_cs_n` is still low, and every `sen_cs_n` line is high.
- R9: At most one `sen_cs_n` line is low at any time. Between two slots all lines stay high for at least one full sensor clock period, and `sen_sck` is low whenever no slot is selected.
- R10: A first-slot byte with bit 7 clear selects config register (byte & (NCFG-1)). A nonzero count writes the register byte into it before the data phase. The data phase then returns size bytes read from consecutive registers, wrapping modulo NCFG, and no sensor is selected.
- R11: Raising `host_cs_n` in mid-frame drops `host_miso_oe` and deselects every sensor. The next frame then works normally.
- R12: After reset `host_miso_oe` and `sen_sck` are low, every `sen_cs_n` is high and all config registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_sck | input | 1 | Host SPI clock, mode 0 |
| host_cs_n | input | 1 | Host frame select, active low |
| host_mosi | input | 1 | Host to bridge data |
| host_miso | output | 1 | Bridge to host data |
| host_miso_oe | output | 1 | Drive enable for host_miso; low means high impedance |
| sen_present | input | NSLOT | One bit per slot, 1 when a sensor is fitted |
| sen_miso | input | 1 | Shared sensor return data |
| sen_sck | output | 1 | Sensor SPI clock, half the block clock when running |
| sen_mosi | output | 1 | Sensor command data |
| sen_cs_n | output | NSLOT | Per-slot sensor select, active low |
| cfg_q | output | 8*NCFG | Config register contents, register k at bits 8k+7:8k |

## Verification
The bench builds the bridge with 34 slots, so a span that starts near slot 31 runs past the end of the array and exercises clipping. It uses a queue depth of only 2, so every multi-byte slot forces the sensor clock to stall, and a full 34-slot sweep keeps the stall path busy for a long stretch. A presence pattern with every third slot empty mixes padded and real slots inside one span. Four config registers make the read-back wrap after a few bytes.

// File: rtl/sburst_pkg.sv
// Shared types for the sensor burst bridge.
// Assumes a four-byte host header with two 6-bit length fields.
package sburst_pkg;

    typedef struct packed {
        logic [7:0] start;
        logic [5:0] size;
        logic [5:0] count;
        logic [7:0] reg_addr;
    } sb_hdr_t;

    typedef enum logic [2:0] {
        E_IDLE, E_NEXT, E_SEL, E_XFER, E_GAP, E_PAD, E_CFG, E_DONE
    } eng_st_t;

    typedef enum logic [1:0] {
        H_HDR, H_DATA, H_REL
    } host_st_t;

endpackage

// File: rtl/sb_fifo.sv
// Small first-word-fall-through byte queue between the sensor engine and host port.
// Assumes push is not issued when full; an empty queue reads as all ones.
module sb_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rp, wp;
    logic [CW-1:0] cnt;
    logic          do_push, do_pop;

    assign full    = (cnt == CW'(DEPTH));
    assign empty   = (cnt == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = empty ? '1 : mem[rp];

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rp  <= '0;
            wp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            cnt <= cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    // Storage write.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end
endmodule

// File: rtl/sb_host_port.sv
// Host-side SPI slave (mode 0), oversampled in the block clock.
// Collects the header, then shifts queued bytes out and releases MISO at the end.
// Assumes the host clock half period spans several block clocks.
module sb_host_port
    import sburst_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    host_sck,
    input  logic    host_cs_n,
    input  logic    host_mosi,
    input  logic [7:0] q_data,
    input  logic    q_empty,
    output logic    q_pop,
    output logic    host_miso,
    output logic    host_miso_oe,
    output logic    frame_on,
    output logic    hdr_valid,
    output sb_hdr_t hdr
);
    logic [2:0] sck_s;
    logic [1:0] cs_s, mo_s;
    logic       rise;
    host_st_t   hst;
    logic [4:0] hcnt;
    logic [30:0] hsh;
    logic [31:0] word;
    logic [2:0] txb;
    logic [7:0] tx_sh;
    logic [11:0] left, total;

    assign rise     = sck_s[1] & ~sck_s[2];
    assign frame_on = ~cs_s[1];
    assign word     = {hsh, mo_s[1]};
    assign total    = word[31] ? 12'(word[21:16]) * 12'(word[13:8]) : 12'(word[21:16]);
    assign q_pop    = (hst == H_DATA) && frame_on && rise && (txb == 3'd0) && !q_empty;
    assign host_miso    = (hst == H_DATA) ? ((txb == 3'd0) ? q_data[7] : tx_sh[7]) : 1'b1;
    assign host_miso_oe = frame_on && (hst != H_REL);

    // Two-stage synchronisers for the host lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_s <= '0;
            cs_s  <= 2'b11;
            mo_s  <= '0;
        end else begin
            sck_s <= {sck_s[1:0], host_sck};
            cs_s  <= {cs_s[0], host_cs_n};
            mo_s  <= {mo_s[0], host_mosi};
        end
    end

    // Frame sequencing: header collection, data shifting, release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst       <= H_HDR;
            hcnt      <= '0;
            hsh       <= '0;
            txb       <= '0;
            tx_sh     <= '1;
            left      <= '0;
            hdr_valid <= 1'b0;
            hdr       <= '0;
        end else begin
            hdr_valid <= 1'b0;
            if (!frame_on) begin
                hst  <= H_HDR;
                hcnt <= '0;
                txb  <= '0;
            end else if (rise) begin
                case (hst)
                    H_HDR: begin
                        hsh  <= word[30:0];
                        hcnt <= hcnt + 1'b1;
                        if (hcnt == 5'd31) begin
                            hdr_valid <= 1'b1;
                            hdr       <= '{start: word[31:24], size: word[21:16],
                                           count: word[13:8], reg_addr: word[7:0]};
                            left      <= total;
                            hst       <= (total == '0) ? H_REL : H_DATA;
                        end
                    end
                    H_DATA: begin
                        txb   <= txb + 1'b1;
                        tx_sh <= (txb == 3'd0) ? {q_data[6:0], 1'b1} : {tx_sh[6:0], 1'b1};
                        if (txb == 3'd7) begin
                            left <= left - 1'b1;
                            if (left == 12'd1) hst <= H_REL;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sb_sensor_master.sv
// Sensor-side SPI master (mode 0, clock = clk/2). Walks the slot span,
// reads present slots, pads absent or out-of-range slots with 0xFF and
// serves config reads. Assumes NCFG is a power of two.
module sb_sensor_master
    import sburst_pkg::*;
#(
    parameter int NSLOT = 34,
    parameter int NCFG  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_on,
    input  logic              hdr_valid,
    input  sb_hdr_t           hdr,
    input  logic [NSLOT-1:0]  present,
    input  logic [NCFG*8-1:0] cfg_flat,
    input  logic              sen_miso,
    input  logic              q_full,
    output logic              q_push,
    output logic [7:0]        q_din,
    output logic              sen_sck,
    output logic              sen_mosi,
    output logic [NSLOT-1:0]  sen_cs_n
);
    localparam int IW = $clog2(NSLOT);
    localparam int CW = (NCFG > 1) ? $clog2(NCFG) : 1;

    eng_st_t          st;
    sb_hdr_t          h;
    logic [7:0]       slot;
    logic [5:0]       remain, k, byte_i;
    logic [2:0]       bit_i;
    logic             sck_q, gap_c;
    logic [7:0]       rx_sh;
    logic [NSLOT-1:0] cs_q;
    logic [2**IW-1:0] pres_ext;
    logic             slot_ok;
    logic [CW-1:0]    cidx;

    assign pres_ext = (2**IW)'(present);
    assign slot_ok  = (int'(slot) < NSLOT) && pres_ext[slot[IW-1:0]];
    assign cidx     = h.start[CW-1:0] + k[CW-1:0];
    assign sen_sck  = sck_q;
    assign sen_cs_n = ~cs_q;
    assign sen_mosi = (st == E_XFER) && (byte_i == '0) && h.reg_addr[~bit_i];
    assign q_push   = ((st == E_PAD || st == E_CFG) && !q_full) ||
                      ((st == E_XFER) && sck_q && (bit_i == 3'd7) && (byte_i != '0));
    assign q_din    = (st == E_PAD) ? 8'hFF :
                      (st == E_CFG) ? cfg_flat[cidx*8 +: 8] : rx_sh;

    // Slot walk, bit shifting and padding.
    always_ff @(posedge clk) begin
        if (!rst_n || !frame_on) begin
            st     <= E_IDLE;
            h      <= '0;
            slot   <= '0;
            remain <= '0;
            k      <= '0;
            byte_i <= '0;
            bit_i  <= '0;
            sck_q  <= 1'b0;
            gap_c  <= 1'b0;
            rx_sh  <= '0;
            cs_q   <= '0;
        end else begin
            case (st)
                E_IDLE: if (hdr_valid) begin
                    h      <= hdr;
                    slot   <= {1'b0, hdr.start[6:0]};
                    remain <= hdr.count;
                    st     <= E_NEXT;
                end
                E_NEXT: begin
                    k <= '0;
                    if (h.size == '0)        st <= E_DONE;
                    else if (!h.start[7])    st <= E_CFG;
                    else if (remain == '0)   st <= E_DONE;
                    else if (slot_ok) begin
                        cs_q <= NSLOT'(1) << slot;
                        st   <= E_SEL;
                    end else                 st <= E_PAD;
                end
                E_SEL: begin
                    bit_i  <= '0;
                    byte_i <= '0;
                    st     <= E_XFER;
                end
                E_XFER: begin
                    if (!sck_q) begin
                        if (byte_i == '0 || bit_i != '0 || !q_full) begin
                            sck_q <= 1'b1;
                            rx_sh <= {rx_sh[6:0], sen_miso};
                        end
                    end else begin
                        sck_q <= 1'b0;
                        bit_i <= bit_i + 1'b1;
                        if (bit_i == 3'd7) begin
                            if (byte_i == h.size) begin
                                cs_q  <= '0;
                                gap_c <= 1'b0;
                                st    <= E_GAP;
                            end else begin
                                byte_i <= byte_i + 1'b1;
                            end
                        end
                    end
                end
                E_GAP: begin
                    gap_c <= 1'b1;
                    if (gap_c) begin
                        slot   <= slot + 1'b1;
                        remain <= remain - 1'b1;
                        st     <= E_NEXT;
                    end
                end
                E_PAD: if (!q_full) begin
                    k <= k + 1'b1;
                    if (k == h.size - 6'd1) begin
                        slot   <= slot + 1'b1;
                        remain <= remain - 1'b1;
                        st     <= E_NEXT;
                    end
                end
                E_CFG: if (!q_full) begin
                    k <= k + 1'b1;
                    if (k == h.size - 6'd1) st <= E_DONE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sensor_burst_bridge.sv
// Top of the sensor burst bridge: host port, byte queue, sensor master and
// the config register file. Assumes NCFG is a power of two.
module sensor_burst_bridge
    import sburst_pkg::*;
#(
    parameter int NSLOT      = 34,
    parameter int NCFG       = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sck,
    input  logic              host_cs_n,
    input  logic              host_mosi,
    output logic              host_miso,
    output logic              host_miso_oe,
    input  logic [NSLOT-1:0]  sen_present,
    input  logic              sen_miso,
    output logic              sen_sck,
    output logic              sen_mosi,
    output logic [NSLOT-1:0]  sen_cs_n,
    output logic [NCFG*8-1:0] cfg_q
);
    localparam int CW = (NCFG > 1) ? $clog2(NCFG) : 1;

    sb_hdr_t    hdr;
    logic       hdr_valid, frame_on;
    logic       ff_push, ff_pop, ff_full, ff_empty;
    logic [7:0] ff_din, ff_dout;

    sb_host_port u_host (
        .clk, .rst_n, .host_sck, .host_cs_n, .host_mosi,
        .q_data(ff_dout), .q_empty(ff_empty), .q_pop(ff_pop),
        .host_miso, .host_miso_oe, .frame_on, .hdr_valid, .hdr
    );

    sb_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk, .rst_n, .flush(!frame_on),
        .push(ff_push), .din(ff_din), .pop(ff_pop),
        .dout(ff_dout), .full(ff_full), .empty(ff_empty)
    );

    sb_sensor_master #(.NSLOT(NSLOT), .NCFG(NCFG)) u_eng (
        .clk, .rst_n, .frame_on, .hdr_valid, .hdr,
        .present(sen_present), .cfg_flat(cfg_q), .sen_miso,
        .q_full(ff_full), .q_push(ff_push), .q_din(ff_din),
        .sen_sck, .sen_mosi, .sen_cs_n
    );

    // Config register write on a header whose first byte has bit 7 clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (hdr_valid && !hdr.start[7] && hdr.count != '0) begin
            cfg_q[hdr.start[CW-1:0]*8 +: 8] <= hdr.reg_addr;
        end
    end
endmodule

// File: rtl/sb_checker.sv
// Protocol checks for the sensor burst bridge, bound to the top module.
module sb_checker #(
    parameter int NSLOT = 34
) (
    input logic             clk,
    input logic             rst_n,
    input logic             frame_on,
    input logic [NSLOT-1:0] sen_cs_n,
    input logic             sen_sck,
    input logic             ff_full,
    input logic             ff_push
);
    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~sen_cs_n)); // R9
    AST_SCK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (&sen_cs_n) |-> !sen_sck); // R9
    AST_SLOT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~$past(sen_cs_n) & sen_cs_n)) |=> (&sen_cs_n)); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ff_full |-> !ff_push); // R7
    AST_ABORT_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |=> (&sen_cs_n)); // R11
endmodule

bind sensor_burst_bridge sb_checker #(.NSLOT(NSLOT)) u_chk (
    .clk(clk), .rst_n(rst_n), .frame_on(frame_on), .sen_cs_n(sen_cs_n),
    .sen_sck(sen_sck), .ff_full(ff_full), .ff_push(ff_push)
);

// File: tb/sensor_burst_bridge_tb.sv
module sensor_burst_bridge_tb;
    localparam int NSLOT = 34;
    localparam int NCFG  = 4;
    localparam int H     = 8;
    localparam int LEAD  = 100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic host_sck = 1'b0, host_cs_n = 1'b1, host_mosi = 1'b0;
    logic host_miso, host_miso_oe;
    logic [NSLOT-1:0] sen_present;
    logic sen_miso, sen_sck, sen_mosi;
    logic [NSLOT-1:0] sen_cs_n;
    logic [NCFG*8-1:0] cfg_q;

    int checks = 0, errors = 0;
    logic [7:0] rx [256];
    logic [7:0] exp_b [256];
    int exp_sel [64];
    int n_exp_sel;
    int sel_log [64];
    logic [7:0] reg_log [64];
    int sel_n = 0;
    logic [7:0] cfg_m [NCFG];

    always #10 clk = ~clk;

    sensor_burst_bridge #(.NSLOT(NSLOT), .NCFG(NCFG), .FIFO_DEPTH(2)) u_dut (
        .clk, .rst_n, .host_sck, .host_cs_n, .host_mosi, .host_miso, .host_miso_oe,
        .sen_present, .sen_miso, .sen_sck, .sen_mosi, .sen_cs_n, .cfg_q
    );

    function automatic bit pres(int s);
        return (s % 3) != 1;
    endfunction

    function automatic logic [7:0] sdat(int s, logic [7:0] r, int k);
        return 8'((s * 7) ^ int'(r) ^ (k * 29));
    endfunction

    // Sensor array model: one shared model keyed by the selected slot.
    int act = -1;
    int rcnt = 0;
    logic [7:0] rsh = '0;
    logic [7:0] cur_reg = '0;
    logic miso_r = 1'b0;
    assign sen_miso = miso_r;

    always @(sen_cs_n) begin
        act = -1;
        for (int i = 0; i < NSLOT; i++) if (!sen_cs_n[i]) act = i;
        rcnt = 0;
        if (act >= 0 && sel_n < 64) begin
            sel_log[sel_n] = act;
            sel_n++;
        end
    end

    always @(posedge sen_sck) if (act >= 0) begin
        rsh = {rsh[6:0], sen_mosi};
        rcnt++;
        if (rcnt == 8) begin
            cur_reg = rsh;
            if (sel_n > 0) reg_log[sel_n - 1] = rsh;
        end
    end

    always @(negedge sen_sck) if (act >= 0 && rcnt >= 8) begin
        logic [7:0] d;
        d = sdat(act, cur_reg, (rcnt - 8) / 8);
        miso_r = d[7 - ((rcnt - 8) % 8)];
    end

    task automatic chk(input bit ok, input string what, input int a, input int e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", what, a, e);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Host side: header then nrecv data bytes; host_cs_n stays low.
    task automatic host_frame(input logic [7:0] h0, h1, h2, h3, input int nrecv);
        logic [31:0] w;
        w = {h0, h1, h2, h3};
        sel_n = 0;
        host_cs_n = 1'b0;
        wait_clk(4);
        for (int i = 31; i >= 0; i--) begin
            host_mosi = w[i];
            wait_clk(H);
            host_sck = 1'b1;
            wait_clk(H);
            host_sck = 1'b0;
        end
        wait_clk(LEAD);
        for (int b = 0; b < nrecv; b++) begin
            logic [7:0] v;
            v = '0;
            for (int i = 0; i < 8; i++) begin
                wait_clk(H);
                v = {v[6:0], host_miso};
                host_sck = 1'b1;
                wait_clk(H);
                host_sck = 1'b0;
            end
            rx[b] = v;
        end
    endtask

    task automatic host_end();
        host_cs_n = 1'b1;
        wait_clk(10);
    endtask

    // Sensor span frame with independent expectations (R1,R3..R8).
    task automatic t_span(input string tag, input logic [7:0] s0, sz_b, ct_b, rg);
        int sz, ct, n;
        sz = int'(sz_b & 8'h3F);
        ct = int'(ct_b & 8'h3F);
        n = 0;
        n_exp_sel = 0;
        for (int i = 0; i < ct; i++) begin
            int s;
            s = int'(s0 & 8'h7F) + i;
            if (s < NSLOT && pres(s)) begin
                exp_sel[n_exp_sel] = s;
                n_exp_sel++;
            end
            for (int k = 0; k < sz; k++) begin
                exp_b[n] = (s < NSLOT && pres(s)) ? sdat(s, rg, k) : 8'hFF;
                n++;
            end
        end
        host_frame(s0, sz_b, ct_b, rg, n);
        for (int b = 0; b < n; b++)
            chk(rx[b] === exp_b[b], $sformatf("%s byte %0d", tag, b), rx[b], exp_b[b]);
        chk(sel_n == n_exp_sel, {tag, " R3 select count"}, sel_n, n_exp_sel);
        for (int j = 0; j < n_exp_sel && j < sel_n; j++) begin
            chk(sel_log[j] == exp_sel[j], {tag, " R3 slot order"}, sel_log[j], exp_sel[j]);
            chk(reg_log[j] == rg, {tag, " R4 register byte"}, reg_log[j], rg);
        end
        wait_clk(10);
        chk(host_miso_oe == 1'b0, {tag, " R8 miso released"}, host_miso_oe, 0);
        chk(&sen_cs_n, {tag, " R8 sensors deselected"}, sen_cs_n, '1);
        host_end();
    endtask

    // Config access (R10) against a bench mirror.
    task automatic t_cfg(input logic [7:0] s0, sz_b, ct_b, rg);
        int sz, ix;
        sz = int'(sz_b & 8'h3F);
        ix = int'(s0) % NCFG;
        if ((ct_b & 8'h3F) != 0) cfg_m[ix] = rg;
        host_frame(s0, sz_b, ct_b, rg, sz);
        for (int b = 0; b < sz; b++)
            chk(rx[b] === cfg_m[(ix + b) % NCFG], $sformatf("R10 cfg byte %0d", b),
                rx[b], cfg_m[(ix + b) % NCFG]);
        chk(sel_n == 0, "R10 no sensor selected", sel_n, 0);
        for (int r = 0; r < NCFG; r++)
            chk(cfg_q[r*8 +: 8] == cfg_m[r], $sformatf("R10 cfg reg %0d", r), cfg_q[r*8 +: 8], cfg_m[r]);
        wait_clk(10);
        chk(host_miso_oe == 1'b0, "R8 miso released after cfg", host_miso_oe, 0);
        host_end();
    endtask

    task automatic t_reset();
        chk(host_miso_oe == 1'b0, "R12 oe after reset", host_miso_oe, 0);
        chk(sen_sck == 1'b0, "R12 sck after reset", sen_sck, 0);
        chk(&sen_cs_n, "R12 selects after reset", sen_cs_n, '1);
        chk(cfg_q == '0, "R12 cfg after reset", cfg_q, 0);
    endtask

    task automatic t_abort();
        host_frame(8'h80, 8'h04, 8'h02, 8'h8F, 1);
        chk(rx[0] === sdat(0, 8'h8F, 0), "R11 first byte before abort", rx[0], sdat(0, 8'h8F, 0));
        host_cs_n = 1'b1;
        wait_clk(10);
        chk(host_miso_oe == 1'b0, "R11 oe after abort", host_miso_oe, 0);
        chk(&sen_cs_n, "R11 selects after abort", sen_cs_n, '1);
        t_span("R11 frame after abort", 8'h91, 8'h01, 8'h01, 8'h8F);
    endtask

    initial begin
        for (int i = 0; i < NSLOT; i++) sen_present[i] = pres(i);
        for (int r = 0; r < NCFG; r++) cfg_m[r] = '0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        t_reset();
        t_span("R3 single slot 17", 8'h91, 8'h01, 8'h01, 8'h8F);
        t_span("R5 span with absent slot", 8'h80, 8'h02, 8'h04, 8'hA8);
        t_span("R2 masked length fields", 8'h80, 8'hC2, 8'h43, 8'h99);
        t_span("R6 clipped span", 8'h9F, 8'h02, 8'h05, 8'hB3);
        t_span("R7 full sweep", 8'h80, 8'h01, 8'h22, 8'h8F);
        t_span("R7 stalled multi-byte", 8'h82, 8'h05, 8'h02, 8'hC0);
        t_cfg(8'h03, 8'h01, 8'h01, 8'hC3);
        t_cfg(8'h01, 8'h03, 8'h01, 8'h5A);
        t_cfg(8'h02, 8'h03, 8'h00, 8'h11);
        t_abort();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule